// File: doc/BRIEF.md
# Generic Timer Fractional Rate Prescaler

This block turns a steady stream of input clock cycles into the count-enable strobe that drives the cores' generic timer counter. A 32-bit rate value sets the output rate. The output rate equals the input rate times 2^31 divided by the rate value. A rate value of 0x8000_0000 therefore gives exactly one count per input cycle, and larger values slow the counter by a fractional ratio. A phase accumulator produces the fractional rate. Between ticks, it keeps the remainder of the division. It never restarts the ratio from zero.

Two mode inputs shape the count. The first input chooses the source. When it is low, every clock cycle counts as an input cycle; this is the crystal oscillator path, nominally 19.2 MHz. When it is high, only cycles in which an alternate-source tick input is high count. The second mode input sets the step to one or two per tick. The block contains the wide timer counter itself. It also reports each increment as a strobe with the amount added, so that a timer comparator elsewhere can follow the count.

Top module: `tmr_rate_prescaler`

## Requirements
- R1: While reset is high, and in the cycle after it, the counter reads zero and the strobe and amount outputs read zero.
- R2: With a rate value of 0x8000_0000, every input cycle produces a tick. The counter advances at every clock edge that has an input cycle, and the strobe and the new count appear together after that edge.
- R3: With a rate value above 0x8000_0000, and the phase starting from reset, the number of ticks after n input cycles equals floor(n * 2^31 / rate).
- R4: A nonzero rate value below 0x8000_0000 asks for more than one tick per input cycle. The block saturates this to one tick on every input cycle.
- R5: A rate value of zero produces no ticks, and the counter holds its value.
- R6: With the step input low, each tick adds 1 to the counter and inc_amount_o reads 1. With the step input high, each tick adds 2 and inc_amount_o reads 2. inc_amount_o reads 0 in any cycle without a strobe.
- R7: With the source input high, only cycles with alt_tick_i high are input cycles. With the source input low, every cycle is an input cycle and alt_tick_i has no effect.
- R8: Changing the rate value does not clear the accumulated phase. For example, run one input cycle at 0xC000_0000 and then one at 0xFFFF_FFFF. The second cycle ticks, where a cleared phase would not.
- R9: The counter wraps from its all-ones value to zero, or to one on a step of 2 from all-ones, and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one crystal input cycle |
| rst | input | 1 | Synchronous active-high reset |
| rate_i | input | ACC_W | Rate value; output rate = input rate * 2^31 / rate_i |
| use_alt_i | input | 1 | 0: every cycle is an input cycle; 1: only cycles with alt_tick_i high |
| alt_tick_i | input | 1 | Tick-valid from the alternate source |
| double_step_i | input | 1 | 0: step of 1 per tick; 1: step of 2 per tick |
| inc_strobe_o | output | 1 | High for one cycle after each tick |
| inc_amount_o | output | 2 | Amount added with the strobe (1 or 2), 0 otherwise |
| count_o | output | CNT_W | Timer counter value |

## Verification
The hardest behaviour to reach from the ports is the counter wrap. At the default 64-bit width, the counter would need 2^64 ticks to wrap, and the block has no load path. The bench therefore adds a second instance with a 4-bit counter, driven by the same stimulus. It runs that instance through all-ones at both step sizes. The phase carry-over (R8) is the other subtle case. The bench brings it about by changing the rate value after a single non-ticking cycle, a point where a cleared phase and a kept phase give different results.

// File: rtl/tmr_rate_pkg.sv
package tmr_rate_pkg;

    typedef struct packed {
        logic use_alt;
        logic double_step;
    } mode_t;

    typedef struct packed {
        logic       strobe;
        logic [1:0] amount;
    } incr_t;

    function automatic logic [1:0] step_size(input logic double_step);
        return double_step ? 2'd2 : 2'd1;
    endfunction

    function automatic logic input_cycle(input mode_t m, input logic alt_tick);
        return m.use_alt ? alt_tick : 1'b1;
    endfunction

endpackage

// File: rtl/tmr_phase_acc.sv
module tmr_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_cycle,
    input  logic [ACC_W-1:0] rate,
    output logic             tick
);
    localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (ACC_W-1);

    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] phase_d;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   rate_ext;

    always_comb begin
        rate_ext = {1'b0, rate};
        sum      = {1'b0, phase_q} + HALF;
        tick     = 1'b0;
        phase_d  = phase_q;
        if (in_cycle && (rate != '0)) begin
            if (rate_ext <= HALF) begin
                tick = 1'b1;
            end else if (sum >= rate_ext) begin
                tick    = 1'b1;
                phase_d = ACC_W'(sum - rate_ext);
            end else begin
                phase_d = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/tmr_wide_counter.sv
module tmr_wide_counter
    import tmr_rate_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             double_step,
    output incr_t            incr,
    output logic [CNT_W-1:0] count
);
    logic [1:0] amt;

    assign amt = tick ? step_size(double_step) : 2'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            count       <= '0;
            incr.strobe <= 1'b0;
            incr.amount <= 2'd0;
        end else begin
            count       <= count + CNT_W'(amt);
            incr.strobe <= tick;
            incr.amount <= amt;
        end
    end
endmodule

// File: rtl/tmr_rate_prescaler.sv
module tmr_rate_prescaler
    import tmr_rate_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate_i,
    input  logic             use_alt_i,
    input  logic             alt_tick_i,
    input  logic             double_step_i,
    output logic             inc_strobe_o,
    output logic [1:0]       inc_amount_o,
    output logic [CNT_W-1:0] count_o
);
    mode_t mode;
    incr_t incr;
    logic  in_cycle;
    logic  tick;

    assign mode.use_alt     = use_alt_i;
    assign mode.double_step = double_step_i;
    assign in_cycle         = input_cycle(mode, alt_tick_i);

    tmr_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .in_cycle (in_cycle),
        .rate     (rate_i),
        .tick     (tick)
    );

    tmr_wide_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .double_step (mode.double_step),
        .incr        (incr),
        .count       (count_o)
    );

    assign inc_strobe_o = incr.strobe;
    assign inc_amount_o = incr.amount;
endmodule

// File: rtl/tmr_rate_prescaler_chk.sv
module tmr_rate_prescaler_chk #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] rate_i,
    input logic             use_alt_i,
    input logic             alt_tick_i,
    input logic             double_step_i,
    input logic             inc_strobe_o,
    input logic [1:0]       inc_amount_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [ACC_W-1:0] UNITY = ACC_W'(1) << (ACC_W-1);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (count_o == '0 && !inc_strobe_o && inc_amount_o == 2'd0));

    // R2 / R9: counter moves by exactly the reported amount, wrapping
    a_r2_count_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_o == $past(count_o) + CNT_W'(inc_amount_o));

    // R2
    a_r2_unity_ticks: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rate_i == UNITY) && $past(!use_alt_i || alt_tick_i))
        |-> inc_strobe_o);

    // R5
    a_r5_zero_rate: assert property (@(posedge clk) disable iff (rst)
        $past(rate_i == '0) |-> !inc_strobe_o);

    // R6
    a_r6_step_amount: assert property (@(posedge clk) disable iff (rst)
        (inc_strobe_o && !$past(rst)) |-> inc_amount_o == ($past(double_step_i) ? 2'd2 : 2'd1));

    a_r6_idle_amount: assert property (@(posedge clk) disable iff (rst)
        !inc_strobe_o |-> inc_amount_o == 2'd0);

    // R7
    a_r7_alt_gate: assert property (@(posedge clk) disable iff (rst)
        $past(use_alt_i && !alt_tick_i) |-> !inc_strobe_o);
endmodule

bind tmr_rate_prescaler tmr_rate_prescaler_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rate_i        (rate_i),
    .use_alt_i     (use_alt_i),
    .alt_tick_i    (alt_tick_i),
    .double_step_i (double_step_i),
    .inc_strobe_o  (inc_strobe_o),
    .inc_amount_o  (inc_amount_o),
    .count_o       (count_o)
);

// File: tb/sim_tmr_rate_prescaler.sv
module sim_tmr_rate_prescaler;
    localparam time CLK_PERIOD = 10ns;
    localparam int  SMALL_W    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rate = 32'h8000_0000;
    logic        use_alt = 1'b0;
    logic        alt_tick = 1'b0;
    logic        dbl = 1'b0;
    logic        strobe;
    logic [1:0]  amount;
    logic [63:0] count;
    logic        strobe1;
    logic [1:0]  amount1;
    logic [SMALL_W-1:0] count1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_rate_prescaler u0 (
        .clk(clk), .rst(rst), .rate_i(rate), .use_alt_i(use_alt),
        .alt_tick_i(alt_tick), .double_step_i(dbl),
        .inc_strobe_o(strobe), .inc_amount_o(amount), .count_o(count));

    tmr_rate_prescaler #(.ACC_W(32), .CNT_W(SMALL_W)) u1 (
        .clk(clk), .rst(rst), .rate_i(rate), .use_alt_i(use_alt),
        .alt_tick_i(alt_tick), .double_step_i(dbl),
        .inc_strobe_o(strobe1), .inc_amount_o(amount1), .count_o(count1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rate = 32'h8000_0000; use_alt = 0; dbl = 0;
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 strobe", {63'd0, strobe}, 0);
        chk("R1 amount", {62'd0, amount}, 0);
        step();
        chk("R1 count after first edge", count, 1);
    endtask

    task automatic t_unity();
        rate = 32'h8000_0000; use_alt = 0; dbl = 0;
        do_reset();
        for (int n = 1; n <= 20; n++) begin
            step();
            chk("R2 count", count, n);
            chk("R2 strobe", {63'd0, strobe}, 1);
        end
    endtask

    task automatic t_fraction(input logic [31:0] r, input int cycles);
        rate = r; use_alt = 0; dbl = 0;
        do_reset();
        for (int n = 1; n <= cycles; n++) begin
            longint unsigned exp;
            step();
            exp = (longint'(n) << 31) / longint'(r);
            chk("R3 ratio", count, exp);
        end
    endtask

    task automatic t_saturate(input logic [31:0] r);
        rate = r; use_alt = 0; dbl = 0;
        do_reset();
        repeat (10) step();
        chk("R4 saturated count", count, 10);
        chk("R4 strobe", {63'd0, strobe}, 1);
    endtask

    task automatic t_zero();
        rate = 32'h0; use_alt = 0; dbl = 0;
        do_reset();
        repeat (25) begin
            step();
            if (strobe) chk("R5 strobe", 1, 0);
        end
        chk("R5 count held", count, 0);
    endtask

    task automatic t_step2();
        rate = 32'h8000_0000; use_alt = 0; dbl = 1;
        do_reset();
        for (int n = 1; n <= 8; n++) begin
            step();
            chk("R6 count step2", count, 2 * n);
            chk("R6 amount 2", {62'd0, amount}, 2);
        end
        dbl = 0;
        step();
        chk("R6 count step1", count, 17);
        chk("R6 amount 1", {62'd0, amount}, 1);
        rate = 32'h0;
        step();
        chk("R6 amount idle", {62'd0, amount}, 0);
    endtask

    task automatic t_alt();
        int exp;
        rate = 32'h8000_0000; use_alt = 1; dbl = 0;
        do_reset();
        exp = 0;
        for (int n = 0; n < 24; n++) begin
            alt_tick = (n % 3 == 1) || (n % 5 == 0);
            if (alt_tick) exp++;
            step();
            chk("R7 strobe follows alt tick", {63'd0, strobe}, {63'd0, alt_tick});
        end
        chk("R7 alt count", count, exp);
        use_alt = 0; alt_tick = 0;
        repeat (5) step();
        chk("R7 alt ignored on crystal", count, exp + 5);
    endtask

    task automatic t_phase_keep();
        rate = 32'hC000_0000; use_alt = 0; dbl = 0;
        do_reset();
        step();
        chk("R8 no tick first cycle", count, 0);
        rate = 32'hFFFF_FFFF;
        step();
        chk("R8 phase kept", count, 1);
    endtask

    task automatic t_wrap();
        rate = 32'h8000_0000; use_alt = 0; dbl = 0;
        do_reset();
        repeat (15) step();
        chk("R9 small all ones", {60'd0, count1}, 15);
        step();
        chk("R9 wrap to zero", {60'd0, count1}, 0);
        step();
        chk("R9 after wrap", {60'd0, count1}, 1);
        dbl = 1;
        repeat (7) step();
        chk("R9 step2 at all ones", {60'd0, count1}, 15);
        step();
        chk("R9 step2 wrap to one", {60'd0, count1}, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_unity();
        t_fraction(32'hC000_0000, 30);
        t_fraction(32'hFFFF_FFFF, 40);
        t_fraction(32'hA000_0001, 50);
        t_saturate(32'h4000_0000);
        t_saturate(32'h0000_0001);
        t_zero();
        t_step2();
        t_alt();
        t_phase_keep();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule